// File: doc/BRIEF.md
# Direct-Addressed Data Cache

A small data cache whose lines are found by a per-set associative tag match, extended with a file of location registers. A check-and-set access does the usual tag match. On a hit it also records where the matching line physically sits (its set and way) in a named location register. Later direct accesses name that register and a short in-line offset. They go straight to the data array without comparing any tag, which is where a tag-matched cache spends most of its energy.

The cache keeps location registers coherent with the arrays. Whenever a line leaves its slot, every register holding that slot is cleared on the same edge. This happens either when a refill replaces the line or when an eviction is requested for it. A direct access through a cleared register is caught before the array is used and is reported as a fault, so software can re-issue the check-and-set form. Misses are reported with a line-aligned refill request. The environment answers through a one-cycle refill port that installs the line into a round-robin victim way of its set.

Every request gets its response one cycle later on registered outputs.

Top module: `daCache`

## Requirements
- R1: The effective address splits as byte-in-line bits [4:0], word bits [4:2], bank bits [7:5], sub-bank bit [8] and an 18-bit tag in bits [26:9]. Bits [31:27] take no part in lookup, so addresses differing only there reach the same line.
- R2: A normal access (reqKind 0) uses reqBase plus the sign-extended 16-bit reqOffset. On a tag hit a load returns the word in rspRdata and a store (reqWrite=1) writes it. rspValid and the result appear on the cycle after the request.
- R3: A normal or check-and-set access that misses gives rspHit=0 and rspRdata=0, and pulses refillReq with refillAddr equal to the address with bits [4:0] cleared. The named location register is left unchanged. Hit, fault, misalign and refill are mutually exclusive.
- R4: A refill (fillValid, fillAddr, fillData with word w in bits [32w+31:32w]) installs the line into the victim way of its set. Each set has its own victim pointer, starting at way 0 and advancing by one per refill. A refill validates no location register.
- R5: A check-and-set access (reqKind 1) that hits behaves as a normal hit and also records the hit line's location in register reqDar, marking it valid.
- R6: A direct access (reqKind 2) through a valid register ignores reqBase and the tag. It reaches word reqOffset[4:2] of the recorded line and reports a hit. A direct store changes only that word; the line's tag and valid state are unchanged.
- R7: A direct access through an invalid register reports rspFault, returns rspRdata=0 and writes nothing. reqKind 3 behaves exactly as a normal access.
- R8: When a refill replaces a line, every location register pointing at that slot becomes invalid on that edge. Registers pointing elsewhere keep working.
- R9: An eviction request (evictValid, evictAddr) that matches a resident line clears that line's valid bit and invalidates all registers pointing at it. Later accesses to it miss.
- R10: A word access with address bits [1:0] nonzero (reqOffset[1:0] for direct access) reports rspMisalign only: no hit, no refill, no fault, no write, no register update.
- R11: A request issued in the same cycle as a refill or eviction sees the arrays as they were before that edge. A check-and-set hit on a line leaving in that cycle reports the hit and its old data but leaves the register invalid. A store to a line replaced in that cycle is discarded in favour of the refill data.
- R12: After reset all lines and all location registers are invalid, every victim pointer is at way 0 and all response outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqKind | input | 2 | 0 normal, 1 check-and-set, 2 direct, 3 as normal |
| reqWrite | input | 1 | 1 store, 0 load |
| reqDar | input | 3 | Location register index |
| reqBase | input | 32 | Base address (unused by direct access) |
| reqOffset | input | 16 | Signed immediate; bits [4:0] for direct access |
| reqWdata | input | 32 | Store data |
| fillValid | input | 1 | Install a line this cycle |
| fillAddr | input | 32 | Address of the line being installed |
| fillData | input | 256 | Line contents, word 0 in the low bits |
| evictValid | input | 1 | Evict the line matching evictAddr |
| evictAddr | input | 32 | Address of the line to evict |
| rspValid | output | 1 | Response for the previous cycle's request |
| rspRdata | output | 32 | Load data, 0 unless a load hit |
| rspHit | output | 1 | Access found its line |
| rspFault | output | 1 | Direct access through an invalid register |
| rspMisalign | output | 1 | Request ignored as misaligned |
| refillReq | output | 1 | Miss; line must be refilled |
| refillAddr | output | 32 | Line-aligned miss address |

## Verification
The sharpest overlap is a request meeting line maintenance on the same edge. One case is a check-and-set hit whose line is evicted in the very cycle that would validate its register. The other is a store to a line that a refill is replacing. The bench drives both events on one falling edge. It expects the response to report the pre-edge hit and data. A following direct access through that register must fault, and a read of the newly installed line must show refill data rather than the store value.

// File: rtl/daCachePkg.sv
package daCachePkg;
  parameter int ADDR_W = 32;
  parameter int DATA_W = 32;
  parameter int IMM_W  = 16;
  parameter int OFF_W  = 5;
  parameter int BANK_W = 3;
  parameter int SUB_W  = 1;
  parameter int TAG_W  = 18;
  parameter int WAYS   = 4;
  parameter int NDAR   = 8;

  localparam int BYTE_W    = $clog2(DATA_W / 8);
  localparam int WORD_W    = OFF_W - BYTE_W;
  localparam int WPL       = 2 ** WORD_W;
  localparam int LINE_BITS = WPL * DATA_W;
  localparam int SET_W     = BANK_W + SUB_W;
  localparam int NSETS     = 2 ** SET_W;
  localparam int WAY_W     = $clog2(WAYS);
  localparam int LINE_W    = SET_W + WAY_W;
  localparam int NLINES    = 2 ** LINE_W;
  localparam int TAG_LSB   = OFF_W + SET_W;
  localparam int DAR_W     = $clog2(NDAR);

  typedef enum logic [1:0] {
    OP_NORMAL   = 2'd0,
    OP_CHECKSET = 2'd1,
    OP_DIRECT   = 2'd2,
    OP_ALIAS    = 2'd3
  } opKind_e;

  typedef struct packed {
    logic hit;
    logic doRead;
    logic doWrite;
    logic setDar;
    logic fault;
    logic misalign;
    logic miss;
  } strobe_t;
endpackage

// File: rtl/daCacheCtrl.sv
module daCacheCtrl
  import daCachePkg::*;
(
  input  logic              reqValid,
  input  logic [1:0]        reqKind,
  input  logic              reqWrite,
  input  logic [BYTE_W-1:0] lowBits,
  input  logic              camMatch,
  input  logic              darOk,
  output strobe_t           strobe
);
  logic isDirect, isCheckSet, aligned, accepted, camHit, directHit;

  always_comb begin
    isDirect   = (reqKind == 2'(OP_DIRECT));
    isCheckSet = (reqKind == 2'(OP_CHECKSET));
    aligned    = (lowBits == '0);
    accepted   = reqValid && aligned;
    camHit     = accepted && !isDirect && camMatch;
    directHit  = accepted && isDirect && darOk;

    strobe.misalign = reqValid && !aligned;
    strobe.fault    = accepted && isDirect && !darOk;
    strobe.miss     = accepted && !isDirect && !camMatch;
    strobe.hit      = camHit || directHit;
    strobe.doWrite  = strobe.hit && reqWrite;
    strobe.doRead   = strobe.hit && !reqWrite;
    strobe.setDar   = camHit && isCheckSet;
  end
endmodule

// File: rtl/daCacheDp.sv
module daCacheDp
  import daCachePkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic [1:0]           reqKind,
  input  logic [DAR_W-1:0]     reqDar,
  input  logic [ADDR_W-1:0]    reqBase,
  input  logic [IMM_W-1:0]     reqOffset,
  input  logic [DATA_W-1:0]    reqWdata,
  input  logic                 fillValid,
  input  logic [ADDR_W-1:0]    fillAddr,
  input  logic [LINE_BITS-1:0] fillData,
  input  logic                 evictValid,
  input  logic [ADDR_W-1:0]    evictAddr,
  input  strobe_t              strobe,
  output logic                 camMatch,
  output logic                 darOk,
  output logic [BYTE_W-1:0]    lowBits,
  output logic                 rspValid,
  output logic [DATA_W-1:0]    rspRdata,
  output logic                 rspHit,
  output logic                 rspFault,
  output logic                 rspMisalign,
  output logic                 refillReq,
  output logic [ADDR_W-1:0]    refillAddr
);
  // Arrays
  logic [NLINES-1:0] validQ;
  logic [TAG_W-1:0]  tagQ   [NLINES];
  logic [DATA_W-1:0] dataQ  [NLINES*WPL];
  logic [WAY_W-1:0]  rrQ    [NSETS];
  logic [NDAR-1:0]   darValidQ;
  logic [LINE_W-1:0] darLocQ [NDAR];

  // Request decode
  logic [ADDR_W-1:0] effAddr;
  logic              isDirect;
  logic [SET_W-1:0]  reqSet;
  logic [TAG_W-1:0]  reqTag;
  logic [WAYS-1:0]   camVec;
  logic [WAY_W-1:0]  camWay;
  logic [LINE_W-1:0] newLine, accLine;
  logic [WORD_W-1:0] accWord;
  logic [DATA_W-1:0] rdWord;

  assign effAddr  = reqBase + {{(ADDR_W-IMM_W){reqOffset[IMM_W-1]}}, reqOffset};
  assign isDirect = (reqKind == 2'(OP_DIRECT));
  assign reqSet   = effAddr[TAG_LSB-1:OFF_W];
  assign reqTag   = effAddr[TAG_LSB +: TAG_W];
  assign lowBits  = isDirect ? reqOffset[BYTE_W-1:0] : effAddr[BYTE_W-1:0];

  // Maintenance decode
  logic [SET_W-1:0]  fillSet, evSet;
  logic [TAG_W-1:0]  fillTag, evTag;
  logic [LINE_W-1:0] fillLine, evLine;
  logic [WAYS-1:0]   evVec;
  logic [WAY_W-1:0]  evWay;
  logic              evHit;

  assign fillSet  = fillAddr[TAG_LSB-1:OFF_W];
  assign fillTag  = fillAddr[TAG_LSB +: TAG_W];
  assign fillLine = {fillSet, rrQ[fillSet]};
  assign evSet    = evictAddr[TAG_LSB-1:OFF_W];
  assign evTag    = evictAddr[TAG_LSB +: TAG_W];

  generate
    for (genvar w = 0; w < WAYS; w++) begin : g_cam
      assign camVec[w] = validQ[{reqSet, WAY_W'(w)}] && (tagQ[{reqSet, WAY_W'(w)}] == reqTag);
      assign evVec[w]  = validQ[{evSet, WAY_W'(w)}]  && (tagQ[{evSet, WAY_W'(w)}]  == evTag);
    end
  endgenerate

  always_comb begin
    camWay = '0;
    evWay  = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (camVec[w]) camWay = WAY_W'(w);
      if (evVec[w])  evWay  = WAY_W'(w);
    end
  end

  assign camMatch = |camVec;
  assign evHit    = evictValid && (|evVec);
  assign evLine   = {evSet, evWay};
  assign newLine  = {reqSet, camWay};
  assign darOk    = darValidQ[reqDar];
  assign accLine  = isDirect ? darLocQ[reqDar] : newLine;
  assign accWord  = isDirect ? reqOffset[OFF_W-1:BYTE_W] : effAddr[OFF_W-1:BYTE_W];
  assign rdWord   = dataQ[{accLine, accWord}];

  // Snoop: which registers lose their line on this edge
  logic [NDAR-1:0] darKill;
  logic            newDying;
  always_comb begin
    for (int d = 0; d < NDAR; d++)
      darKill[d] = (fillValid && darLocQ[d] == fillLine) || (evHit && darLocQ[d] == evLine);
    newDying = (fillValid && newLine == fillLine) || (evHit && newLine == evLine);
  end

  logic unusedAddrBits;
  assign unusedAddrBits = ^{fillAddr[OFF_W-1:0], fillAddr[ADDR_W-1:TAG_LSB+TAG_W],
                            evictAddr[OFF_W-1:0], evictAddr[ADDR_W-1:TAG_LSB+TAG_W]};

  // Control state
  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ      <= '0;
      darValidQ   <= '0;
      for (int s = 0; s < NSETS; s++) rrQ[s] <= '0;
      for (int d = 0; d < NDAR; d++) darLocQ[d] <= '0;
      rspValid    <= 1'b0;
      rspRdata    <= '0;
      rspHit      <= 1'b0;
      rspFault    <= 1'b0;
      rspMisalign <= 1'b0;
      refillReq   <= 1'b0;
      refillAddr  <= '0;
    end else begin
      if (evHit) validQ[evLine] <= 1'b0;
      if (fillValid) begin
        validQ[fillLine] <= 1'b1;
        rrQ[fillSet]     <= rrQ[fillSet] + 1'b1;
      end
      for (int d = 0; d < NDAR; d++) begin
        if (darKill[d]) darValidQ[d] <= 1'b0;
        if (strobe.setDar && reqDar == DAR_W'(d)) begin
          darLocQ[d]   <= newLine;
          darValidQ[d] <= !newDying;
        end
      end
      rspValid    <= reqValid;
      rspHit      <= strobe.hit;
      rspFault    <= strobe.fault;
      rspMisalign <= strobe.misalign;
      refillReq   <= strobe.miss;
      rspRdata    <= strobe.doRead ? rdWord : '0;
      refillAddr  <= strobe.miss ? {effAddr[ADDR_W-1:OFF_W], OFF_W'(0)} : '0;
    end
  end

  // Tag and data arrays
  always_ff @(posedge clk) begin
    if (strobe.doWrite && !(fillValid && accLine == fillLine))
      dataQ[{accLine, accWord}] <= reqWdata;
    if (fillValid) begin
      tagQ[fillLine] <= fillTag;
      for (int w = 0; w < WPL; w++)
        dataQ[{fillLine, WORD_W'(w)}] <= fillData[w*DATA_W +: DATA_W];
    end
  end
endmodule

// File: rtl/daCache.sv
module daCache
  import daCachePkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic [1:0]           reqKind,
  input  logic                 reqWrite,
  input  logic [DAR_W-1:0]     reqDar,
  input  logic [ADDR_W-1:0]    reqBase,
  input  logic [IMM_W-1:0]     reqOffset,
  input  logic [DATA_W-1:0]    reqWdata,
  input  logic                 fillValid,
  input  logic [ADDR_W-1:0]    fillAddr,
  input  logic [LINE_BITS-1:0] fillData,
  input  logic                 evictValid,
  input  logic [ADDR_W-1:0]    evictAddr,
  output logic                 rspValid,
  output logic [DATA_W-1:0]    rspRdata,
  output logic                 rspHit,
  output logic                 rspFault,
  output logic                 rspMisalign,
  output logic                 refillReq,
  output logic [ADDR_W-1:0]    refillAddr
);
  strobe_t           strobe;
  logic              camMatch, darOk;
  logic [BYTE_W-1:0] lowBits;

  daCacheCtrl u_ctrl (
    .reqValid (reqValid),
    .reqKind  (reqKind),
    .reqWrite (reqWrite),
    .lowBits  (lowBits),
    .camMatch (camMatch),
    .darOk    (darOk),
    .strobe   (strobe)
  );

  daCacheDp u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .reqKind     (reqKind),
    .reqDar      (reqDar),
    .reqBase     (reqBase),
    .reqOffset   (reqOffset),
    .reqWdata    (reqWdata),
    .fillValid   (fillValid),
    .fillAddr    (fillAddr),
    .fillData    (fillData),
    .evictValid  (evictValid),
    .evictAddr   (evictAddr),
    .strobe      (strobe),
    .camMatch    (camMatch),
    .darOk       (darOk),
    .lowBits     (lowBits),
    .rspValid    (rspValid),
    .rspRdata    (rspRdata),
    .rspHit      (rspHit),
    .rspFault    (rspFault),
    .rspMisalign (rspMisalign),
    .refillReq   (refillReq),
    .refillAddr  (refillAddr)
  );
endmodule

// File: rtl/daCacheChk.sv
module daCacheChk
  import daCachePkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic [1:0]        reqKind,
  input logic [IMM_W-1:0]  reqOffset,
  input logic              rspValid,
  input logic [DATA_W-1:0] rspRdata,
  input logic              rspHit,
  input logic              rspFault,
  input logic              rspMisalign,
  input logic              refillReq,
  input logic [ADDR_W-1:0] refillAddr
);
  // R2
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);

  // R2
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);

  // R3
  outcome_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({rspHit, rspFault, rspMisalign, refillReq}));

  // R3
  refill_aligned_chk: assert property (@(posedge clk) disable iff (!rstN)
    refillReq |-> (rspValid && refillAddr[OFF_W-1:0] == '0 && rspRdata == '0));

  // R7
  fault_no_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspFault |-> (rspRdata == '0 && rspValid));

  // R10
  misalign_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspMisalign |-> (rspRdata == '0 && rspValid));

  // R6
  direct_resolves_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqKind == 2'(OP_DIRECT) && reqOffset[BYTE_W-1:0] == '0) |=> (rspHit != rspFault));
endmodule

bind daCache daCacheChk u_daCacheChk (
  .clk         (clk),
  .rstN        (rstN),
  .reqValid    (reqValid),
  .reqKind     (reqKind),
  .reqOffset   (reqOffset),
  .rspValid    (rspValid),
  .rspRdata    (rspRdata),
  .rspHit      (rspHit),
  .rspFault    (rspFault),
  .rspMisalign (rspMisalign),
  .refillReq   (refillReq),
  .refillAddr  (refillAddr)
);

// File: tb/daCache_bench.sv
module daCache_bench;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         reqValid = 1'b0;
  logic [1:0]   reqKind = 2'd0;
  logic         reqWrite = 1'b0;
  logic [2:0]   reqDar = 3'd0;
  logic [31:0]  reqBase = '0;
  logic [15:0]  reqOffset = '0;
  logic [31:0]  reqWdata = '0;
  logic         fillValid = 1'b0;
  logic [31:0]  fillAddr = '0;
  logic [255:0] fillData = '0;
  logic         evictValid = 1'b0;
  logic [31:0]  evictAddr = '0;
  logic         rspValid, rspHit, rspFault, rspMisalign, refillReq;
  logic [31:0]  rspRdata, refillAddr;

  int checkCnt = 0;
  int failCnt = 0;
  bit done = 1'b0;

  localparam logic [1:0] K_NORM = 2'd0, K_SET = 2'd1, K_DIR = 2'd2, K_ALT = 2'd3;
  localparam logic [3:0] O_HIT = 4'b1000, O_FAULT = 4'b0100, O_MIS = 4'b0010, O_MISS = 4'b0001;
  localparam logic [31:0] LA = 32'h0000_1000;  // bank 0, sub 0
  localparam logic [31:0] LB = 32'h0000_1120;  // bank 1, sub 1
  localparam logic [31:0] LC = 32'h0000_2040;  // bank 2, sub 0
  localparam logic [31:0] LD = 32'h0000_6060;  // bank 3, sub 0

  always #4 clk = ~clk;

  daCache u_daCache (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind), .reqWrite(reqWrite),
    .reqDar(reqDar), .reqBase(reqBase), .reqOffset(reqOffset), .reqWdata(reqWdata),
    .fillValid(fillValid), .fillAddr(fillAddr), .fillData(fillData),
    .evictValid(evictValid), .evictAddr(evictAddr),
    .rspValid(rspValid), .rspRdata(rspRdata), .rspHit(rspHit), .rspFault(rspFault),
    .rspMisalign(rspMisalign), .refillReq(refillReq), .refillAddr(refillAddr)
  );

  function automatic logic [31:0] fw(logic [31:0] line, int w);
    return line + 32'(w * 4) + 32'hA500_0000;
  endfunction

  function automatic logic [31:0] rrAddr(int t);   // bank 5, sub 1
    return (32'(t) << 9) | 32'h1A0;
  endfunction

  function automatic logic [31:0] eAddr(int t);    // bank 6, sub 0
    return (32'(t) << 9) | 32'h0C0;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic checkOut(string tag, logic [3:0] exp);
    check(tag, {28'd0, rspHit, rspFault, rspMisalign, refillReq}, {28'd0, exp});
  endtask

  task automatic setReq(logic [1:0] k, logic wr, logic [2:0] d, logic [31:0] b, logic [15:0] o, logic [31:0] wd);
    reqValid = 1'b1; reqKind = k; reqWrite = wr; reqDar = d;
    reqBase = b; reqOffset = o; reqWdata = wd;
  endtask

  task automatic setFill(logic [31:0] a);
    fillValid = 1'b1; fillAddr = a;
    for (int w = 0; w < 8; w++) fillData[w*32 +: 32] = fw(a, w);
  endtask

  task automatic clearAll();
    reqValid = 1'b0; fillValid = 1'b0; evictValid = 1'b0;
  endtask

  task automatic req(logic [1:0] k, logic wr, logic [2:0] d, logic [31:0] b, logic [15:0] o, logic [31:0] wd);
    @(negedge clk); setReq(k, wr, d, b, o, wd);
    @(negedge clk); clearAll();
  endtask

  task automatic fill(logic [31:0] a);
    @(negedge clk); setFill(a);
    @(negedge clk); clearAll();
  endtask

  task automatic evict(logic [31:0] a);
    @(negedge clk); evictValid = 1'b1; evictAddr = a;
    @(negedge clk); clearAll();
  endtask

  task automatic tReset();
    check("R12 rspValid after reset", {31'd0, rspValid}, 32'd0);
    checkOut("R12 outputs after reset", 4'b0000);
    req(K_NORM, 1'b0, 3'd0, LA, 16'd0, '0);
    checkOut("R12 cold cache misses", O_MISS);
    check("R3 refill address", refillAddr, LA);
    check("R3 miss returns no data", rspRdata, 32'd0);
  endtask

  task automatic tNormal();
    fill(LA);
    req(K_NORM, 1'b0, 3'd0, LA, 16'd8, '0);
    checkOut("R2 load hit", O_HIT);
    check("R2 load data", rspRdata, fw(LA, 2));
    req(K_NORM, 1'b0, 3'd0, LA + 32'd64, 16'hFFC8, '0);
    check("R2 negative offset", rspRdata, fw(LA, 2));
    req(K_NORM, 1'b0, 3'd0, LA | 32'hF800_0000, 16'h14, '0);
    checkOut("R1 upper bits ignored", O_HIT);
    check("R1 alias data", rspRdata, fw(LA, 5));
    req(K_NORM, 1'b1, 3'd0, LA, 16'h1C, 32'h0000_1234);
    req(K_NORM, 1'b0, 3'd0, LA, 16'h1C, '0);
    check("R2 store then load", rspRdata, 32'h0000_1234);
  endtask

  task automatic tCheckSet();
    req(K_SET, 1'b0, 3'd3, LA, 16'd4, '0);
    checkOut("R5 check-and-set hit", O_HIT);
    check("R5 check-and-set data", rspRdata, fw(LA, 1));
    req(K_DIR, 1'b0, 3'd3, 32'hDEAD_0000, 16'd12, '0);
    checkOut("R6 direct hit", O_HIT);
    check("R6 direct data", rspRdata, fw(LA, 3));
    req(K_DIR, 1'b1, 3'd3, 32'h0, 16'd16, 32'h0000_CAFE);
    req(K_NORM, 1'b0, 3'd0, LA, 16'd16, '0);
    check("R6 direct store visible", rspRdata, 32'h0000_CAFE);
    req(K_NORM, 1'b0, 3'd0, LA, 16'd0, '0);
    check("R6 tag intact after direct store", rspRdata, fw(LA, 0));
    req(K_DIR, 1'b0, 3'd5, LA, 16'd0, '0);
    checkOut("R7 invalid register faults", O_FAULT);
    check("R7 fault data", rspRdata, 32'd0);
    req(K_ALT, 1'b0, 3'd0, LA, 16'd4, '0);
    check("R7 kind 3 acts as normal", rspRdata, fw(LA, 1));
  endtask

  task automatic tMisalign();
    req(K_NORM, 1'b0, 3'd0, LA, 16'd2, '0);
    checkOut("R10 misaligned load", O_MIS);
    req(K_NORM, 1'b1, 3'd0, LA, 16'h19, 32'h0000_0BAD);
    checkOut("R10 misaligned store", O_MIS);
    req(K_NORM, 1'b0, 3'd0, LA, 16'h18, '0);
    check("R10 store ignored", rspRdata, fw(LA, 6));
    req(K_DIR, 1'b0, 3'd3, 32'h0, 16'd5, '0);
    checkOut("R10 misaligned direct", O_MIS);
  endtask

  task automatic tCheckMiss();
    req(K_SET, 1'b0, 3'd4, LB, 16'd0, '0);
    checkOut("R3 check-and-set miss", O_MISS);
    check("R3 check-and-set refill addr", refillAddr, LB);
    req(K_DIR, 1'b0, 3'd4, 32'h0, 16'd0, '0);
    checkOut("R3 register stays invalid", O_FAULT);
    fill(LB);
    req(K_DIR, 1'b0, 3'd4, 32'h0, 16'd0, '0);
    checkOut("R4 refill validates no register", O_FAULT);
    req(K_NORM, 1'b0, 3'd0, LB, 16'd0, '0);
    check("R4 refilled data", rspRdata, fw(LB, 0));
  endtask

  task automatic tEvict();
    fill(LC);
    req(K_SET, 1'b0, 3'd1, LA, 16'd0, '0);
    req(K_SET, 1'b0, 3'd2, LA, 16'd8, '0);
    req(K_SET, 1'b0, 3'd6, LC, 16'd0, '0);
    evict(LA);
    req(K_DIR, 1'b0, 3'd1, 32'h0, 16'd0, '0);
    checkOut("R8 first register cleared", O_FAULT);
    req(K_DIR, 1'b0, 3'd2, 32'h0, 16'd0, '0);
    checkOut("R8 second register cleared", O_FAULT);
    req(K_DIR, 1'b0, 3'd6, 32'h0, 16'd4, '0);
    check("R8 other register kept", rspRdata, fw(LC, 1));
    req(K_NORM, 1'b0, 3'd0, LA, 16'd0, '0);
    checkOut("R9 evicted line misses", O_MISS);
    req(K_NORM, 1'b0, 3'd0, LC, 16'd0, '0);
    check("R9 other line still hits", rspRdata, fw(LC, 0));
  endtask

  task automatic tRoundRobin();
    for (int t = 16; t < 20; t++) fill(rrAddr(t));
    req(K_SET, 1'b0, 3'd0, rrAddr(16), 16'd0, '0);
    fill(rrAddr(20));
    req(K_DIR, 1'b0, 3'd0, 32'h0, 16'd0, '0);
    checkOut("R8 replaced line clears register", O_FAULT);
    req(K_NORM, 1'b0, 3'd0, rrAddr(16), 16'd0, '0);
    checkOut("R4 oldest way was the victim", O_MISS);
    for (int t = 17; t < 21; t++) begin
      req(K_NORM, 1'b0, 3'd0, rrAddr(t), 16'd4, '0);
      check("R4 remaining ways hit", rspRdata, fw(rrAddr(t), 1));
    end
  endtask

  task automatic tConflict();
    fill(LD);
    @(negedge clk);
    setReq(K_SET, 1'b0, 3'd7, LD, 16'd0, '0);
    evictValid = 1'b1; evictAddr = LD;
    @(negedge clk); clearAll();
    checkOut("R11 hit seen before eviction", O_HIT);
    check("R11 old data returned", rspRdata, fw(LD, 0));
    req(K_DIR, 1'b0, 3'd7, 32'h0, 16'd0, '0);
    checkOut("R11 register not validated", O_FAULT);

    for (int t = 64; t < 68; t++) fill(eAddr(t));
    @(negedge clk);
    setReq(K_NORM, 1'b1, 3'd0, eAddr(64), 16'd0, 32'h0000_5555);
    setFill(eAddr(68));
    @(negedge clk); clearAll();
    checkOut("R11 store hit reported", O_HIT);
    req(K_NORM, 1'b0, 3'd0, eAddr(68), 16'd0, '0);
    check("R11 refill data wins over store", rspRdata, fw(eAddr(68), 0));
    req(K_NORM, 1'b0, 3'd0, eAddr(64), 16'd0, '0);
    checkOut("R11 replaced line misses", O_MISS);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tNormal();
    tCheckSet();
    tMisalign();
    tCheckMiss();
    tEvict();
    tRoundRobin();
    tConflict();
    done = 1'b1;
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checkCnt++;
      failCnt++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
      $finish;
    end
  end
endmodule